// File: doc/BRIEF.md
# Stage-Based Temperature Estimator

This block estimates die temperature in millidegrees Celsius when no temperature converter is available. Its inputs are the coarse alarm stage (0 to 3) reported by a thermal comparator and a 2-bit threshold select. The threshold select shifts the whole trip ladder upwards in 5000 m°C steps from a 105000 m°C base, and the stages are 20000 m°C apart. From these the block derives the three trip-point temperatures and a temperature estimate.

The estimate depends on which way the stage moved. On a rise, the block reports the lower edge of the new band plus 2000 m°C of hysteresis. On a fall, it reports the upper edge of the new band minus the same hysteresis. If the stage did not move, the estimate does not change.

A load strobe seeds the estimator at start-up with the current stage. A valid strobe delivers each later stage sample. A one-cycle event pulse marks every sample whose stage differs from the last stage that was announced.

Top module: `stage_temp_estimator`

## Requirements
- R1: While reset is held and right after it, `temp_o` is 37000, `changed_o` is 0, the stored stage is 0 and the trip outputs are 105000, 125000 and 145000 (threshold 0).
- R2: A load with stage 0 sets `temp_o` to the default estimate, 37000 by default, whatever the threshold. This takes effect one cycle after the strobe.
- R3: A load with a nonzero stage s sets `temp_o` to 105000 + 5000·thresh + 20000·(s−1), with no hysteresis, one cycle after the strobe.
- R4: A sample whose stage s is above the stored stage sets `temp_o` to 105000 + 5000·thresh + 20000·(s−1) + 2000.
- R5: A sample whose stage s is below the stored stage sets `temp_o` to 105000 + 5000·thresh + 20000·s − 2000.
- R6: A sample equal to the stored stage leaves `temp_o` unchanged. Every sample and every load replaces the stored stage.
- R7: On each load or sample, the trip outputs become T1 = 105000 + 5000·thresh, T2 = T1 + 20000 and T3 = T1 + 40000, one cycle after the strobe.
- R8: `changed_o` pulses for one cycle, one cycle after a sample whose stage differs from the last announced stage; that sample then becomes the announced stage. Loads neither pulse nor alter the announced stage, which is 0 after reset.
- R9: When load and sample are asserted in the same cycle, the load behaviour alone applies.
- R10: With neither strobe asserted, `temp_o` and the trip outputs hold, and `changed_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Initialisation strobe |
| sample_i | input | 1 | Stage sample valid strobe |
| stage_i | input | 2 | Reported alarm stage, 0 to 3 |
| thresh_i | input | 2 | Threshold select, 0 to 3 |
| temp_o | output | 32 | Estimated temperature, m°C |
| trip1_o | output | 32 | Stage 1 trip temperature, m°C |
| trip2_o | output | 32 | Stage 2 trip temperature, m°C |
| trip3_o | output | 32 | Critical stage 3 trip temperature, m°C |
| changed_o | output | 1 | One-cycle stage change event |

## Verification
The in-module assertions check the following on every cycle:
- outputs hold when no strobe arrives;
- an equal-stage sample leaves the estimate alone;
- a rise lands the estimate above the first trip and a fall lands it below the critical trip;
- no event fires without a sample, or when a load is also asserted.

The exact millidegree values need the bench's scenarios. These cover every threshold setting, rises and falls across several bands, and a repeated stage that differs from the announced one only because a load changed the stored stage in between. They also cover a load arriving together with a sample.

// File: rtl/ste_pkg.sv
package ste_pkg;
    parameter int TEMP_W  = 32;
    parameter int STAGE_W = 2;
    parameter int THR_W   = 2;

    typedef struct packed {
        logic [TEMP_W-1:0]  temp;
        logic [TEMP_W-1:0]  trip1;
        logic [TEMP_W-1:0]  trip2;
        logic [TEMP_W-1:0]  trip3;
        logic [STAGE_W-1:0] stage;
        logic [STAGE_W-1:0] announced;
        logic               changed;
    } est_state_t;
endpackage

// File: rtl/ste_trip_calc.sv
module ste_trip_calc
    import ste_pkg::*;
#(
    parameter int unsigned BASE_MC   = 105000,
    parameter int unsigned THR_STEP  = 5000,
    parameter int unsigned STG_STEP  = 20000
) (
    input  logic [THR_W-1:0]  thresh_i,
    output logic [TEMP_W-1:0] trip1_o,
    output logic [TEMP_W-1:0] trip2_o,
    output logic [TEMP_W-1:0] trip3_o
);
    localparam logic [TEMP_W-1:0] BASE_V = TEMP_W'(BASE_MC);
    localparam logic [TEMP_W-1:0] THR_V  = TEMP_W'(THR_STEP);
    localparam logic [TEMP_W-1:0] STG_V  = TEMP_W'(STG_STEP);

    always_comb begin
        trip1_o = BASE_V + THR_V * TEMP_W'(thresh_i);
        trip2_o = trip1_o + STG_V;
        trip3_o = trip2_o + STG_V;
    end
endmodule

// File: rtl/ste_bound_sel.sv
module ste_bound_sel
    import ste_pkg::*;
#(
    parameter int unsigned STG_STEP     = 20000,
    parameter int unsigned HYST_MC      = 2000,
    parameter int unsigned DEFAULT_MC   = 37000
) (
    input  logic               init_i,
    input  logic [STAGE_W-1:0] new_stage_i,
    input  logic [STAGE_W-1:0] old_stage_i,
    input  logic [TEMP_W-1:0]  trip1_i,
    input  logic [TEMP_W-1:0]  cur_temp_i,
    output logic [TEMP_W-1:0]  est_o
);
    localparam logic [TEMP_W-1:0] STG_V  = TEMP_W'(STG_STEP);
    localparam logic [TEMP_W-1:0] HYST_V = TEMP_W'(HYST_MC);
    localparam logic [TEMP_W-1:0] DEF_V  = TEMP_W'(DEFAULT_MC);

    logic [TEMP_W-1:0] band_top;
    logic [TEMP_W-1:0] band_bottom;

    always_comb begin
        // band_top: trip of the stage above; band_bottom: trip of this stage
        band_top    = trip1_i + STG_V * TEMP_W'(new_stage_i);
        band_bottom = band_top - STG_V;
        if (init_i) begin
            est_o = (new_stage_i == '0) ? DEF_V : band_bottom;
        end else if (new_stage_i > old_stage_i) begin
            est_o = band_bottom + HYST_V;
        end else if (new_stage_i < old_stage_i) begin
            est_o = band_top - HYST_V;
        end else begin
            est_o = cur_temp_i;
        end
    end
endmodule

// File: rtl/stage_temp_estimator.sv
module stage_temp_estimator
    import ste_pkg::*;
#(
    parameter int unsigned DEFAULT_MC = 37000,
    parameter int unsigned BASE_MC    = 105000,
    parameter int unsigned THR_STEP   = 5000,
    parameter int unsigned STG_STEP   = 20000,
    parameter int unsigned HYST_MC    = 2000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               sample_i,
    input  logic [1:0]         stage_i,
    input  logic [1:0]         thresh_i,
    output logic [31:0]        temp_o,
    output logic [31:0]        trip1_o,
    output logic [31:0]        trip2_o,
    output logic [31:0]        trip3_o,
    output logic               changed_o
);
    localparam logic [TEMP_W-1:0] RST_T1 = TEMP_W'(BASE_MC);
    localparam logic [TEMP_W-1:0] RST_T2 = TEMP_W'(BASE_MC + STG_STEP);
    localparam logic [TEMP_W-1:0] RST_T3 = TEMP_W'(BASE_MC + 2 * STG_STEP);

    est_state_t st_d, st_q;

    logic [TEMP_W-1:0] t1_w, t2_w, t3_w, est_w;

    ste_trip_calc #(
        .BASE_MC (BASE_MC),
        .THR_STEP(THR_STEP),
        .STG_STEP(STG_STEP)
    ) u_trip (
        .thresh_i(thresh_i),
        .trip1_o (t1_w),
        .trip2_o (t2_w),
        .trip3_o (t3_w)
    );

    ste_bound_sel #(
        .STG_STEP  (STG_STEP),
        .HYST_MC   (HYST_MC),
        .DEFAULT_MC(DEFAULT_MC)
    ) u_bound (
        .init_i     (load_i),
        .new_stage_i(stage_i),
        .old_stage_i(st_q.stage),
        .trip1_i    (t1_w),
        .cur_temp_i (st_q.temp),
        .est_o      (est_w)
    );

    always_comb begin
        st_d         = st_q;
        st_d.changed = 1'b0;
        if (load_i || sample_i) begin
            st_d.temp  = est_w;
            st_d.trip1 = t1_w;
            st_d.trip2 = t2_w;
            st_d.trip3 = t3_w;
            st_d.stage = stage_i;
        end
        // Load wins: only a bare sample announces a new stage
        if (sample_i && !load_i && stage_i != st_q.announced) begin
            st_d.changed   = 1'b1;
            st_d.announced = stage_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.temp      <= TEMP_W'(DEFAULT_MC);
            st_q.trip1     <= RST_T1;
            st_q.trip2     <= RST_T2;
            st_q.trip3     <= RST_T3;
            st_q.stage     <= '0;
            st_q.announced <= '0;
            st_q.changed   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign temp_o    = st_q.temp;
    assign trip1_o   = st_q.trip1;
    assign trip2_o   = st_q.trip2;
    assign trip3_o   = st_q.trip3;
    assign changed_o = st_q.changed;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !sample_i) |=> ($stable(temp_o) && $stable(trip1_o) && !changed_o)); // R10

    AST_EQUAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !load_i && stage_i == st_q.stage) |=> $stable(temp_o)); // R6

    AST_RISE_ABOVE_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !load_i && stage_i > st_q.stage) |=> (temp_o > trip1_o)); // R4

    AST_FALL_BELOW_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !load_i && stage_i < st_q.stage) |=> (temp_o < trip3_o)); // R5

    AST_NO_SPURIOUS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_i || load_i) |=> !changed_o); // R8

    AST_LOAD_STAGE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.stage == $past(stage_i))); // R9
endmodule

// File: tb/tb_stage_temp_estimator.sv
module tb_stage_temp_estimator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic        sample_i = 1'b0;
    logic [1:0]  stage_i = '0;
    logic [1:0]  thresh_i = '0;
    logic [31:0] temp_o, trip1_o, trip2_o, trip3_o;
    logic        changed_o;

    always #5 clk = ~clk;

    stage_temp_estimator dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .sample_i(sample_i),
        .stage_i(stage_i), .thresh_i(thresh_i), .temp_o(temp_o),
        .trip1_o(trip1_o), .trip2_o(trip2_o), .trip3_o(trip3_o),
        .changed_o(changed_o)
    );

    typedef struct {
        int unsigned temp;
        int unsigned t1;
        int unsigned t2;
        int unsigned t3;
        bit          chg;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit driver_done = 1'b0;

    // reference model state
    int unsigned m_temp = 37000, m_t1 = 105000, m_t2 = 125000, m_t3 = 145000;
    int unsigned m_stage = 0, m_ann = 0;

    task automatic check(string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_op(bit ld, bit smp, int unsigned stg, int unsigned thr, string tag);
        exp_t e;
        int unsigned base;
        bit chg;
        @(negedge clk);
        load_i   = ld;
        sample_i = smp;
        stage_i  = 2'(stg);
        thresh_i = 2'(thr);
        base = 105000 + 5000 * thr;
        chg = 1'b0;
        if (ld || smp) begin
            if (ld) begin
                m_temp = (stg == 0) ? 37000 : base + 20000 * (stg - 1);
            end else if (stg > m_stage) begin
                m_temp = base + 20000 * (stg - 1) + 2000;
            end else if (stg < m_stage) begin
                m_temp = base + 20000 * stg - 2000;
            end
            m_t1 = base; m_t2 = base + 20000; m_t3 = base + 40000;
            m_stage = stg;
            if (smp && !ld && stg != m_ann) begin
                chg = 1'b1;
                m_ann = stg;
            end
        end
        e.temp = m_temp; e.t1 = m_t1; e.t2 = m_t2; e.t3 = m_t3;
        e.chg = chg; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        load_i = 1'b0;
        sample_i = 1'b0;
    endtask

    // monitor: outputs settle after the edge that captured the op
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " temp"}, temp_o, e.temp);
                check({e.tag, " trip1 R7"}, trip1_o, e.t1);
                check({e.tag, " trip2 R7"}, trip2_o, e.t2);
                check({e.tag, " trip3 R7"}, trip3_o, e.t3);
                check({e.tag, " event R8"}, 32'(changed_o), 32'(e.chg));
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset temp", temp_o, 37000);
        check("R1 reset trip1", trip1_o, 105000);
        check("R1 reset trip3", trip3_o, 145000);
        check("R1 reset event", 32'(changed_o), 0);
        rst_n = 1'b1;
        do_op(0, 0, 3, 2, "R10 idle after reset");
        do_op(1, 0, 0, 1, "R2 load stage0");
        do_op(0, 1, 0, 1, "R6 equal stage0");
        do_op(0, 1, 1, 1, "R4 rise to 1");
        do_op(0, 1, 1, 1, "R6 repeat 1");
        do_op(0, 1, 3, 1, "R4 rise to 3");
        do_op(0, 0, 0, 3, "R10 idle");
        do_op(0, 1, 2, 1, "R5 fall to 2");
        do_op(0, 1, 0, 3, "R5 fall to 0");
        do_op(1, 0, 2, 2, "R3 load stage2");
        do_op(0, 1, 2, 2, "R6 equal after load R8 announce");
        do_op(1, 1, 3, 0, "R9 load with sample");
        do_op(0, 1, 0, 0, "R5 fall from 3");
        do_op(0, 0, 0, 0, "R10 final idle");
        driver_done = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule